// File: doc/BRIEF.md
# Serial-Fed Quadrature Position Counters

This block keeps four quadrature position counters for two game-controller ports, an X and a Y counter for each port. The eight quadrature lines do not reach it as parallel pins. An external parallel-to-serial converter captures them. The block drives that converter with a one-cycle load strobe, then clocks the eight sampled bits out of it with a serial clock that the block generates. The converter advances on each rising serial-clock edge, and the block samples the incoming bit at that same edge.

After all eight bits of a frame are in, the block commits the samples in a single cycle. Each counter compares the new Gray-coded pair with the state held in its own two low bits and steps up or down by one. An illegal double step leaves the upper bits as they were.

Each port is read as a 16-bit word, with Y in the high byte and X in the low byte. The low two bits of each counter are the binary form of its input pair, so they also give the four joystick switch states for each port. A test write presets the upper six bits of all four counters in one cycle.

The sequencer has four named states:
- `ST_LOAD`: strobe high for one cycle.
- `ST_SCLK_LO`: serial clock low for `HALF_CYC` cycles.
- `ST_SCLK_HI`: serial clock high for `HALF_CYC` cycles.
- `ST_COMMIT`: one cycle in which the counters update.

Its transitions are:
- LOAD→SCLK_LO, always.
- SCLK_LO→SCLK_HI when the half period ends. The bit is captured on this transition.
- SCLK_HI→SCLK_LO when the half period ends and bits remain.
- SCLK_HI→COMMIT after the eighth bit.
- COMMIT→LOAD, always.

Top module: `mouse_serial_counters`

## Requirements
- R1: During and right after reset:
  - all four counters read zero;
  - the sequencer is in the load state (`ser_load` = 1, `ser_clk` = 0);
  - all direction outputs are 0.
- R2: A frame has the following timing, and the strobe and the serial clock are never high together:
  - `ser_load` is high for exactly one cycle;
  - eight serial-clock periods follow, each `HALF_CYC` cycles low then `HALF_CYC` cycles high;
  - one commit cycle ends the frame;
  - strobe pulses are therefore 2+16·`HALF_CYC` cycles apart.
- R3: `ser_data` is sampled at the clock edge where `ser_clk` rises. The k-th bit received (k = 0 first) feeds the counters as follows:
  - bits 0 and 1 are port 0 X, as (A, B);
  - bits 2 and 3 are port 0 Y, as (A, B);
  - bits 4 and 5 are port 1 X, as (A, B);
  - bits 6 and 7 are port 1 Y, as (A, B).
- R4: The counters change only at the end of a complete 8-bit frame (or on a test write). The read words hold their value throughout a frame and take new values at the cycle in which the next load strobe is visible.
- R5: On commit, a counter's input pair (A, B) maps to a binary phase {B, B^A}. The counter then moves by the phase difference d = new − old low bits (mod 4):
  - d = 1: the counter adds one;
  - d = 3: the counter subtracts one;
  - d = 0: no change.
  - The low two bits always equal the phase.
- R6: A double step (d = 2) leaves bits 7:2 unchanged and sets the low two bits to the new phase.
- R7: Counters wrap modulo 256: 255 + 1 gives 0, and 0 − 1 gives 255.
- R8: `port0_word` = {Y0, X0} and `port1_word` = {Y1, X1}, each with Y in bits 15:8 and X in bits 7:0.
- R9: A test write (`test_we` = 1 for one cycle) has effect one cycle later:
  - `test_data[15:10]` goes into Y[7:2] of both ports;
  - `test_data[7:2]` goes into X[7:2] of both ports;
  - the low two bits of every counter are untouched;
  - later frames count on from the preset value.
- R10: A test write in the commit cycle takes bits 7:2 from the test data and the low two bits from the new phase.
- R11: Each `portN_dir` is derived from that port's counter low bits:
  - bit 0 (forward) = Y1^Y0;
  - bit 1 (left) = Y1;
  - bit 2 (back) = X1^X0;
  - bit 3 (right) = X1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_load | output | 1 | Parallel-load strobe to the external converter |
| ser_clk | output | 1 | Serial shift clock to the converter |
| ser_data | input | 1 | Serial bit from the converter |
| test_we | input | 1 | Test preset strobe |
| test_data | input | 2*CNT_W | Test preset value (Y upper in 15:10, X upper in 7:2) |
| port0_word | output | 2*CNT_W | Port 0 position {Y, X} |
| port1_word | output | 2*CNT_W | Port 1 position {Y, X} |
| port0_dir | output | 4 | Port 0 switches {right, back, left, forward} |
| port1_dir | output | 4 | Port 1 switches {right, back, left, forward} |

## Verification
The counters update at the clock edge that leaves the commit state. The new words are therefore first observed at the falling edge on which `ser_load` is high again, which is 2+16·`HALF_CYC` cycles after the strobe that latched the stimulus. The bench synchronises every frame check to that falling edge, and during one frame it checks the words at every falling edge before it.

A test write is checked at the next falling edge after it is driven. The commit-coincident write is driven exactly 1+16·`HALF_CYC` falling edges after a strobe, so that it lands in the commit cycle. Expected counter values come from an arithmetic phase-difference model applied to each frame, including full sweeps over all 256 frame patterns and a 300-step run that wraps in both directions.

// File: rtl/msc_pkg.sv
package msc_pkg;

    typedef enum logic [1:0] {
        ST_LOAD,
        ST_SCLK_LO,
        ST_SCLK_HI,
        ST_COMMIT
    } msc_state_e;

    localparam int NUM_PORTS     = 2;
    localparam int LINES_PER_CNT = 2;
    localparam int NUM_CNT       = 2 * NUM_PORTS;
    localparam int FRAME_BITS    = NUM_CNT * LINES_PER_CNT;

endpackage

// File: rtl/msc_frame_fsm.sv
module msc_frame_fsm
    import msc_pkg::*;
#(
    parameter int HALF_CYC = 2,
    parameter int NBITS    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_data,
    output logic             ser_load,
    output logic             ser_clk,
    output logic             commit,
    output logic [NBITS-1:0] samples
);

    localparam int HC_W = $clog2(HALF_CYC + 1);
    localparam int BI_W = $clog2(NBITS);
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_CYC - 1);
    localparam logic [BI_W-1:0] BI_LAST = BI_W'(NBITS - 1);

    msc_state_e      state_q, state_d;
    logic [HC_W-1:0] hc_q;
    logic [BI_W-1:0] bi_q;
    logic            half_done;
    logic            last_bit;

    assign half_done = (hc_q == HC_LAST);
    assign last_bit  = (bi_q == BI_LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:    state_d = ST_SCLK_LO;
            ST_SCLK_LO: if (half_done) state_d = ST_SCLK_HI;
            ST_SCLK_HI: if (half_done) state_d = last_bit ? ST_COMMIT : ST_SCLK_LO;
            ST_COMMIT:  state_d = ST_LOAD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    // half-period timer, bit index and sample capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hc_q    <= '0;
            bi_q    <= '0;
            samples <= '0;
        end else begin
            unique case (state_q)
                ST_LOAD: begin
                    hc_q <= '0;
                    bi_q <= '0;
                end
                ST_SCLK_LO: begin
                    if (half_done) begin
                        hc_q          <= '0;
                        samples[bi_q] <= ser_data;
                    end else begin
                        hc_q <= hc_q + 1'b1;
                    end
                end
                ST_SCLK_HI: begin
                    if (half_done) begin
                        hc_q <= '0;
                        if (!last_bit) bi_q <= bi_q + 1'b1;
                    end else begin
                        hc_q <= hc_q + 1'b1;
                    end
                end
                ST_COMMIT: hc_q <= '0;
            endcase
        end
    end

    // Moore outputs
    always_comb begin
        ser_load = 1'b0;
        ser_clk  = 1'b0;
        commit   = 1'b0;
        unique case (state_q)
            ST_LOAD:    ser_load = 1'b1;
            ST_SCLK_LO: ser_clk  = 1'b0;
            ST_SCLK_HI: ser_clk  = 1'b1;
            ST_COMMIT:  commit   = 1'b1;
        endcase
    end

endmodule

// File: rtl/msc_quad_counter.sv
module msc_quad_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic             pin_a,
    input  logic             pin_b,
    input  logic             preset_we,
    input  logic [CNT_W-3:0] preset_val,
    output logic [CNT_W-1:0] count
);

    logic [1:0]       phase_new;
    logic [1:0]       delta;
    logic [CNT_W-1:0] stepped;
    logic [CNT_W-1:0] count_d;

    // Gray pair to binary phase; the counter's own low bits hold the previous phase
    assign phase_new = {pin_b, pin_b ^ pin_a};
    assign delta     = phase_new - count[1:0];

    always_comb begin
        unique case (delta)
            2'd0: stepped = count;
            2'd1: stepped = count + CNT_W'(1);
            2'd3: stepped = count - CNT_W'(1);
            2'd2: stepped = {count[CNT_W-1:2], phase_new};
        endcase
    end

    always_comb begin
        count_d = commit ? stepped : count;
        if (preset_we) count_d[CNT_W-1:2] = preset_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= count_d;
    end

endmodule

// File: rtl/mouse_serial_counters.sv
module mouse_serial_counters
    import msc_pkg::*;
#(
    parameter int HALF_CYC = 2,
    parameter int CNT_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               ser_load,
    output logic               ser_clk,
    input  logic               ser_data,
    input  logic               test_we,
    input  logic [2*CNT_W-1:0] test_data,
    output logic [2*CNT_W-1:0] port0_word,
    output logic [2*CNT_W-1:0] port1_word,
    output logic [3:0]         port0_dir,
    output logic [3:0]         port1_dir
);

    logic                  frame_commit;
    logic [FRAME_BITS-1:0] samples;
    logic [CNT_W-1:0]      cnt [NUM_CNT];
    logic [3:0]            dir [NUM_PORTS];

    msc_frame_fsm #(
        .HALF_CYC (HALF_CYC),
        .NBITS    (FRAME_BITS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_data (ser_data),
        .ser_load (ser_load),
        .ser_clk  (ser_clk),
        .commit   (frame_commit),
        .samples  (samples)
    );

    // counter g: even = X, odd = Y; port = g/2
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        logic [CNT_W-3:0] pv;
        if (g % 2 == 1) begin : g_y
            assign pv = test_data[2*CNT_W-1:CNT_W+2];
        end else begin : g_x
            assign pv = test_data[CNT_W-1:2];
        end
        msc_quad_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .commit     (frame_commit),
            .pin_a      (samples[LINES_PER_CNT*g]),
            .pin_b      (samples[LINES_PER_CNT*g+1]),
            .preset_we  (test_we),
            .preset_val (pv),
            .count      (cnt[g])
        );
    end

    // switch decode: {right, back, left, forward}
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dir
        assign dir[p] = {cnt[2*p][1],   cnt[2*p][1] ^ cnt[2*p][0],
                         cnt[2*p+1][1], cnt[2*p+1][1] ^ cnt[2*p+1][0]};
    end

    assign port0_word = {cnt[1], cnt[0]};
    assign port1_word = {cnt[3], cnt[2]};
    assign port0_dir  = dir[0];
    assign port1_dir  = dir[1];

endmodule

// File: rtl/msc_checker.sv
module msc_checker #(
    parameter int CNT_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ser_load,
    input logic               ser_clk,
    input logic               commit,
    input logic               test_we,
    input logic [2*CNT_W-1:0] test_data,
    input logic [2*CNT_W-1:0] port0_word,
    input logic [2*CNT_W-1:0] port1_word
);

    function automatic logic legal_step(input logic [CNT_W-1:0] nv, input logic [CNT_W-1:0] ov);
        logic [CNT_W-1:0] d;
        d = nv - ov;
        return (d == '0) || (d == CNT_W'(1)) || (d == '1) || (nv[CNT_W-1:2] == ov[CNT_W-1:2]);
    endfunction

    assert_load_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ser_load |=> !ser_load);

    assert_load_clk_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_load && ser_clk));

    assert_words_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !test_we) |=> ($stable(port0_word) && $stable(port1_word)));

    assert_preset_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
        test_we |=> (port0_word[2*CNT_W-1:CNT_W+2] == $past(test_data[2*CNT_W-1:CNT_W+2])
                  && port1_word[2*CNT_W-1:CNT_W+2] == $past(test_data[2*CNT_W-1:CNT_W+2])
                  && port0_word[CNT_W-1:2] == $past(test_data[CNT_W-1:2])
                  && port1_word[CNT_W-1:2] == $past(test_data[CNT_W-1:2])));

    assert_unit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !test_we) |=>
            (legal_step(port0_word[CNT_W-1:0], $past(port0_word[CNT_W-1:0]))
          && legal_step(port0_word[2*CNT_W-1:CNT_W], $past(port0_word[2*CNT_W-1:CNT_W]))
          && legal_step(port1_word[CNT_W-1:0], $past(port1_word[CNT_W-1:0]))
          && legal_step(port1_word[2*CNT_W-1:CNT_W], $past(port1_word[2*CNT_W-1:CNT_W]))));

    assert_preset_keeps_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (test_we && !commit) |=> (port0_word[1:0] == $past(port0_word[1:0])
                               && port1_word[1:0] == $past(port1_word[1:0])));

endmodule

bind mouse_serial_counters msc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_load   (ser_load),
    .ser_clk    (ser_clk),
    .commit     (frame_commit),
    .test_we    (test_we),
    .test_data  (test_data),
    .port0_word (port0_word),
    .port1_word (port1_word)
);

// File: tb/mouse_serial_counters_bench.sv
`timescale 1ns/1ps
module mouse_serial_counters_bench;

    localparam int HALF      = 2;
    localparam int CNT       = 8;
    localparam int FRAME_LEN = 2 + 16 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_load, ser_clk, ser_data;
    logic        test_we = 1'b0;
    logic [15:0] test_data = '0;
    logic [15:0] port0_word, port1_word;
    logic [3:0]  port0_dir, port1_dir;

    always #5 clk = ~clk;

    mouse_serial_counters #(.HALF_CYC(HALF), .CNT_W(CNT)) u_mouse_serial_counters (
        .clk(clk), .rst_n(rst_n), .ser_load(ser_load), .ser_clk(ser_clk),
        .ser_data(ser_data), .test_we(test_we), .test_data(test_data),
        .port0_word(port0_word), .port1_word(port1_word),
        .port0_dir(port0_dir), .port1_dir(port1_dir)
    );

    // external parallel-to-serial converter model
    logic [7:0] stim = '0;
    logic [7:0] frame_q = '0;
    logic [3:0] idx = '0;
    logic       sclk_q = 1'b0;
    always @(posedge clk) begin
        sclk_q <= ser_clk;
        if (ser_load) begin
            frame_q <= stim;
            idx     <= '0;
        end else if (ser_clk && !sclk_q) begin
            idx <= idx + 1'b1;
        end
    end
    assign ser_data = (idx < 4'd8) ? frame_q[idx[2:0]] : 1'b0;

    int errs = 0;
    int checks = 0;
    logic [7:0] m [4];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] step8(input logic [7:0] old, input logic [1:0] pins);
        logic [1:0] ph, d;
        ph = {pins[1], pins[1] ^ pins[0]};
        d  = ph - old[1:0];
        case (d)
            2'd1:    return old + 8'd1;
            2'd3:    return old - 8'd1;
            2'd2:    return {old[7:2], ph};
            default: return old;
        endcase
    endfunction

    // bin holds four 2-bit binary phases, counter g in bits 2g+1:2g
    function automatic logic [7:0] stim_of(input logic [7:0] bin);
        logic [7:0] s;
        for (int g = 0; g < 4; g++) begin
            s[2*g]   = bin[2*g] ^ bin[2*g+1];
            s[2*g+1] = bin[2*g+1];
        end
        return s;
    endfunction

    task automatic model_frame(input logic [7:0] s);
        for (int g = 0; g < 4; g++) m[g] = step8(m[g], {s[2*g+1], s[2*g]});
    endtask

    task automatic check_words(input string tag);
        chk(tag, {16'h0, port0_word}, {16'h0, m[1], m[0]});
        chk(tag, {16'h0, port1_word}, {16'h0, m[3], m[2]});
    endtask

    // R11: {right=X1, back=X1^X0, left=Y1, forward=Y1^Y0}
    task automatic check_dirs();
        chk("R11 port0", {28'h0, port0_dir}, {28'h0, m[0][1], m[0][1]^m[0][0], m[1][1], m[1][1]^m[1][0]});
        chk("R11 port1", {28'h0, port1_dir}, {28'h0, m[2][1], m[2][1]^m[2][0], m[3][1], m[3][1]^m[3][0]});
    endtask

    task automatic do_frame(input logic [7:0] s);
        while (!ser_load) @(negedge clk);
        stim = s;
        @(negedge clk);
        while (!ser_load) @(negedge clk);
        model_frame(s);
    endtask

    task automatic test_write(input logic [15:0] d);
        test_data = d;
        test_we   = 1'b1;
        @(negedge clk);
        test_we   = 1'b0;
        m[1][7:2] = d[15:10];
        m[3][7:2] = d[15:10];
        m[0][7:2] = d[7:2];
        m[2][7:2] = d[7:2];
    endtask

    initial begin
        for (int g = 0; g < 4; g++) m[g] = '0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 load", {31'h0, ser_load}, 32'd1);
        chk("R1 sclk", {31'h0, ser_clk}, 32'd0);
        check_words("R1 words");
        rst_n = 1'b1;
        check_dirs();

        // R2 + R4: measured frame with a change on port0 X
        begin
            logic [7:0] s;
            int n, rises, hi, loads;
            logic prev;
            logic [15:0] w0, w1;
            s = stim_of(8'b00_00_00_01);
            stim = s;
            w0 = port0_word; w1 = port1_word;
            n = 0; rises = 0; hi = 0; loads = 0; prev = ser_clk;
            do begin
                @(negedge clk);
                n++;
                if (ser_clk && !prev) rises++;
                if (ser_clk) hi++;
                if (ser_load) loads++;
                prev = ser_clk;
                if (!ser_load) begin
                    chk("R4 hold p0", {16'h0, port0_word}, {16'h0, w0});
                    chk("R4 hold p1", {16'h0, port1_word}, {16'h0, w1});
                end
            end while (!ser_load);
            chk("R2 period", n, FRAME_LEN);
            chk("R2 rises", rises, 8);
            chk("R2 high cycles", hi, 8 * HALF);
            chk("R2 strobe count", loads, 1);
            model_frame(s);
            check_words("R4 commit");
        end

        // R3: bit order, one counter at a time
        do_frame(8'h00);
        check_words("R3 base");
        for (int g = 0; g < 4; g++) begin
            do_frame(stim_of(8'(1 << (2 * g))));
            check_words("R3 single");
            do_frame(8'h00);
            check_words("R3 back");
        end

        // R5 R7: port0 X forward, port1 Y backward, both wrap
        for (int k = 0; k < 300; k++) begin
            logic [1:0] fx, by;
            fx = 2'(k + 1);
            by = 2'(-(k + 1));
            do_frame(stim_of({by, 4'b0000, fx}));
            check_words("R5 R7 sweep");
        end
        chk("R7 up wrap", {24'h0, port0_word[7:0]}, 32'd44);
        chk("R7 down wrap", {24'h0, port1_word[15:8]}, 32'd212);

        // R6: double step on port0 X from phase 0 to phase 2
        do_frame(stim_of(8'b00_00_00_10));
        chk("R6 double", {24'h0, port0_word[7:0]}, 32'd46);
        chk("R6 other", {24'h0, port1_word[15:8]}, 32'd212);

        // R6 R8 R11: every frame pattern in sequence
        for (int v = 0; v < 256; v++) begin
            do_frame(8'(v));
            check_words("R6 R8 all patterns");
            check_dirs();
        end

        // R9: test presets at a load edge
        test_write(16'hA75E);
        check_words("R9 preset A75E");
        test_write(16'hFC03);
        check_words("R9 preset FC03");
        do_frame(stim_of({2'(m[3][1:0] + 2'd1), m[2][1:0], m[1][1:0], 2'(m[0][1:0] + 2'd1)}));
        check_words("R9 counts on");
        check_dirs();

        // R10: preset coinciding with commit
        begin
            logic [7:0] s;
            s = stim_of({m[3][1:0], m[2][1:0], 2'(m[1][1:0] - 2'd1), 2'(m[0][1:0] + 2'd1)});
            stim = s;
            repeat (1 + 16 * HALF) @(negedge clk);
            test_data = 16'h5432;
            test_we   = 1'b1;
            @(negedge clk);
            test_we   = 1'b0;
            chk("R10 at load", {31'h0, ser_load}, 32'd1);
            model_frame(s);
            m[1][7:2] = 6'(16'h5432 >> 10);
            m[3][7:2] = 6'(16'h5432 >> 10);
            m[0][7:2] = 6'(16'h5432 >> 2);
            m[2][7:2] = 6'(16'h5432 >> 2);
            check_words("R10 merge");
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule